// File: doc/BRIEF.md
# Condition-Code Masked Register Writeback

This block is the last stage of a four-lane vector datapath. It takes one result vector, the old value of the destination register and the write controls of an instruction. From these it produces the merged destination value, and it also keeps two four-lane condition-code registers. Each result lane can be clamped to the unit interval. It can then be classified as positive, zero, negative or not-a-number. The lane reaches the destination only when its static mask bit is set and a run-time test passes. That test is made on a swizzled read of one of the two condition-code registers.

A write is presented for one cycle with `wr_valid`. The merged destination appears on `dest_out` after the next rising edge, and any condition-code update lands on that same edge. Condition codes that are read for a test in the same cycle as an update still see the older values. An integer mode sends address-register results through the same merge path. In that mode the lanes are classified as two's-complement numbers and no saturation is applied. Pulsing `run_start` at the start of each program run returns both condition-code registers to all-zero-equal.

Top module: `ccwb_writeback`

## Requirements
- R1: After reset `dest_out` is zero and every lane of both condition-code registers holds EQ. A `run_start` pulse sets every lane of both registers to EQ on the next edge, and this takes priority over any update in the same cycle. Codes are 2 bits per lane, lane 0 in the low bits: GT=00, EQ=01, LT=10, UN=11.
- R2: On a write, destination lane i takes the processed result when `wmask[i]` is 1 and the lane's condition test passes. Otherwise it takes lane i of `dest_in`. Lane i occupies bits [32i+31:32i].
- R3: The test rule is 3 bits: TR=0, FL=1, EQ=2, NE=3, LT=4, GE=5, LE=6, GT=7. TR always passes and FL never passes. GE passes on GT or EQ, and LE passes on LT or EQ. A lane holding UN fails every rule except TR and NE, and NE passes it.
- R4: Test lane i reads the code at the lane index held in `cc_swz[2i+1:2i]`. For example, codes (GT,LT,EQ,GT) read with the swizzle zyxw (fields 2,1,0,3) test as (EQ,LT,GT,GT).
- R5: `cc_rd_sel` selects which condition-code register is read for the test (0 gives `cc0_out`, 1 gives `cc1_out`).
- R6: With `sat_en` set in float mode, a result below zero becomes +0.0 and a result above 1.0 becomes 1.0 (0x3F800000), with +infinity included in the second case. NaN and -0.0 pass through unchanged. Saturation happens before both the merge and the code generation.
- R7: With `cc_upd_en` set, each written lane sets its code in the register picked by `cc_wr_sel`. A NaN (exponent all ones, mantissa nonzero) gives UN. Both +0.0 and -0.0 give EQ. A negative value gives LT and any other value gives GT.
- R8: Code lanes whose destination lane was not written stay unchanged. The register not picked by `cc_wr_sel` is unchanged, and with `cc_upd_en` clear neither register changes.
- R9: With `int_mode` set, saturation is ignored and lanes are classified as signed 32-bit integers: negative gives LT, zero gives EQ and positive gives GT.
- R10: Outputs change only on the edge after `wr_valid` or `run_start`. Otherwise they hold. A test made in the same cycle as an update uses the codes from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_start | input | 1 | Start of program run; clears both code registers to EQ |
| wr_valid | input | 1 | A write is presented this cycle |
| int_mode | input | 1 | Treat result lanes as signed integers |
| sat_en | input | 1 | Clamp float lanes to [0,1] |
| result | input | 128 | Four-lane result vector |
| dest_in | input | 128 | Current destination register value |
| wmask | input | 4 | Static per-lane write mask |
| cc_rd_sel | input | 1 | Code register used for the test |
| cc_rule | input | 3 | Test rule |
| cc_swz | input | 8 | Per-lane swizzle of the code read |
| cc_upd_en | input | 1 | Update a code register from written lanes |
| cc_wr_sel | input | 1 | Code register to update |
| dest_out | output | 128 | Merged destination value |
| cc0_out | output | 8 | Condition-code register 0 |
| cc1_out | output | 8 | Condition-code register 1 |

## Verification
The bench builds the block with its default of four lanes. At that size the 2-bit swizzle fields can address every lane, and every permutation or replication the bench draws is legal. With four lanes a short run covers every mix of mask bits, every rule and every code a lane can hold. The results are drawn from a pool that leans on signed zeros, NaN, infinity and values on each side of the clamp limits. Directed sequences replay the three-step masked write example and the swizzled NE test.

// File: rtl/ccwb_pkg.sv
package ccwb_pkg;

    localparam int FP_W  = 32;
    localparam int EXP_W = 8;
    localparam int MAN_W = 23;

    localparam logic [FP_W-1:0] FP_ONE  = 32'h3F80_0000;
    localparam logic [FP_W-1:0] FP_ZERO = '0;

    typedef enum logic [1:0] {
        CC_GT = 2'b00,
        CC_EQ = 2'b01,
        CC_LT = 2'b10,
        CC_UN = 2'b11
    } cc_e;

    typedef enum logic [2:0] {
        RL_TR = 3'd0,
        RL_FL = 3'd1,
        RL_EQ = 3'd2,
        RL_NE = 3'd3,
        RL_LT = 3'd4,
        RL_GE = 3'd5,
        RL_LE = 3'd6,
        RL_GT = 3'd7
    } rule_e;

    function automatic logic fp_is_nan(input logic [FP_W-1:0] v);
        return (&v[FP_W-2 -: EXP_W]) && (|v[MAN_W-1:0]);
    endfunction

    function automatic cc_e fp_classify(input logic [FP_W-1:0] v);
        if (fp_is_nan(v))               return CC_UN;
        else if (v[FP_W-2:0] == '0)     return CC_EQ;
        else if (v[FP_W-1])             return CC_LT;
        else                            return CC_GT;
    endfunction

    function automatic cc_e int_classify(input logic [FP_W-1:0] v);
        if (v[FP_W-1])        return CC_LT;
        else if (v == '0)     return CC_EQ;
        else                  return CC_GT;
    endfunction

    function automatic logic cc_pass(input rule_e r, input cc_e c);
        case (r)
            RL_TR:   return 1'b1;
            RL_FL:   return 1'b0;
            RL_EQ:   return c == CC_EQ;
            RL_NE:   return c != CC_EQ;
            RL_LT:   return c == CC_LT;
            RL_GE:   return (c == CC_GT) || (c == CC_EQ);
            RL_LE:   return (c == CC_LT) || (c == CC_EQ);
            default: return c == CC_GT;
        endcase
    endfunction

endpackage

// File: rtl/ccwb_lane_proc.sv
module ccwb_lane_proc
    import ccwb_pkg::*;
(
    input  logic [FP_W-1:0] raw,
    input  logic            sat_en,
    input  logic            int_mode,
    output logic [FP_W-1:0] val,
    output cc_e             code
);
    logic nan;
    logic below_zero;
    logic above_one;

    always_comb begin
        nan        = fp_is_nan(raw);
        below_zero = raw[FP_W-1] && (raw[FP_W-2:0] != '0) && !nan;
        above_one  = !raw[FP_W-1] && (raw[FP_W-2:0] > FP_ONE[FP_W-2:0]) && !nan;
        val        = raw;
        if (sat_en && !int_mode) begin
            if (below_zero)     val = FP_ZERO;
            else if (above_one) val = FP_ONE;
        end
        code = int_mode ? int_classify(raw) : fp_classify(val);
    end
endmodule

// File: rtl/ccwb_cond_eval.sv
module ccwb_cond_eval
    import ccwb_pkg::*;
#(
    parameter int LANES = 4,
    localparam int SW_W = $clog2(LANES),
    localparam int CC_W = 2 * LANES
) (
    input  logic [CC_W-1:0]       cc0,
    input  logic [CC_W-1:0]       cc1,
    input  logic                  rd_sel,
    input  logic [2:0]            rule,
    input  logic [LANES*SW_W-1:0] swz,
    output logic [LANES-1:0]      lane_ok
);
    logic [CC_W-1:0] src;

    assign src = rd_sel ? cc1 : cc0;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [SW_W-1:0] idx;
        logic [1:0]      picked;
        assign idx        = swz[i*SW_W +: SW_W];
        assign picked     = src[idx*2 +: 2];
        assign lane_ok[i] = cc_pass(rule_e'(rule), cc_e'(picked));
    end
endmodule

// File: rtl/ccwb_writeback.sv
module ccwb_writeback
    import ccwb_pkg::*;
#(
    parameter int LANES = 4,
    localparam int SW_W = $clog2(LANES),
    localparam int CC_W = 2 * LANES,
    localparam int VW   = LANES * FP_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run_start,
    input  logic                  wr_valid,
    input  logic                  int_mode,
    input  logic                  sat_en,
    input  logic [VW-1:0]         result,
    input  logic [VW-1:0]         dest_in,
    input  logic [LANES-1:0]      wmask,
    input  logic                  cc_rd_sel,
    input  logic [2:0]            cc_rule,
    input  logic [LANES*SW_W-1:0] cc_swz,
    input  logic                  cc_upd_en,
    input  logic                  cc_wr_sel,
    output logic [VW-1:0]         dest_out,
    output logic [CC_W-1:0]       cc0_out,
    output logic [CC_W-1:0]       cc1_out
);
    localparam logic [CC_W-1:0] CC_ALL_EQ = {LANES{CC_EQ}};

    logic [VW-1:0]    lane_val;
    logic [CC_W-1:0]  lane_code;
    logic [LANES-1:0] lane_ok;
    logic [LANES-1:0] lane_wr;

    logic [VW-1:0]    dest_q;
    logic [CC_W-1:0]  cc0_q;
    logic [CC_W-1:0]  cc1_q;

    for (genvar i = 0; i < LANES; i++) begin : g_proc
        cc_e code_i;
        ccwb_lane_proc u_proc (
            .raw      (result[i*FP_W +: FP_W]),
            .sat_en   (sat_en),
            .int_mode (int_mode),
            .val      (lane_val[i*FP_W +: FP_W]),
            .code     (code_i)
        );
        assign lane_code[i*2 +: 2] = code_i;
    end

    ccwb_cond_eval #(.LANES(LANES)) u_cond (
        .cc0     (cc0_q),
        .cc1     (cc1_q),
        .rd_sel  (cc_rd_sel),
        .rule    (cc_rule),
        .swz     (cc_swz),
        .lane_ok (lane_ok)
    );

    assign lane_wr = wmask & lane_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            dest_q <= '0;
            cc0_q  <= CC_ALL_EQ;
            cc1_q  <= CC_ALL_EQ;
        end else begin
            if (wr_valid) begin
                for (int i = 0; i < LANES; i++) begin
                    dest_q[i*FP_W +: FP_W] <= lane_wr[i] ? lane_val[i*FP_W +: FP_W]
                                                         : dest_in[i*FP_W +: FP_W];
                    if (cc_upd_en && lane_wr[i]) begin
                        if (cc_wr_sel) cc1_q[i*2 +: 2] <= lane_code[i*2 +: 2];
                        else           cc0_q[i*2 +: 2] <= lane_code[i*2 +: 2];
                    end
                end
            end
            if (run_start) begin
                cc0_q <= CC_ALL_EQ;
                cc1_q <= CC_ALL_EQ;
            end
        end
    end

    assign dest_out = dest_q;
    assign cc0_out  = cc0_q;
    assign cc1_out  = cc1_q;
endmodule

// File: rtl/ccwb_checker.sv
module ccwb_checker #(
    parameter int LANES = 4,
    localparam int CC_W = 2 * LANES,
    localparam int VW   = LANES * 32
) (
    input logic             clk,
    input logic             rst,
    input logic             run_start,
    input logic             wr_valid,
    input logic [LANES-1:0] wmask,
    input logic [2:0]       cc_rule,
    input logic             cc_upd_en,
    input logic             cc_wr_sel,
    input logic [VW-1:0]    dest_in,
    input logic [VW-1:0]    dest_out,
    input logic [CC_W-1:0]  cc0_out,
    input logic [CC_W-1:0]  cc1_out
);
    localparam logic [CC_W-1:0] ALL_EQ = {LANES{2'b01}};

    // R1: start of a run leaves both code registers at EQ
    a_r1_run_clears: assert property (@(posedge clk) disable iff (rst)
        run_start |=> (cc0_out == ALL_EQ) && (cc1_out == ALL_EQ));

    // R3: the FL rule blocks every lane
    a_r3_fl_blocks: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && cc_rule == 3'd1) |=> dest_out == $past(dest_in));

    // R8: no update request leaves both code registers alone
    a_r8_no_upd_holds: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !cc_upd_en && !run_start) |=> $stable(cc0_out) && $stable(cc1_out));

    // R8: the register not targeted stays put
    a_r8_other_reg_holds: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && cc_upd_en && !run_start) |=>
            (cc_wr_sel ? $stable(cc0_out) : $stable(cc1_out)));

    // R10: idle cycles change nothing
    a_r10_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!wr_valid && !run_start) |=>
            $stable(dest_out) && $stable(cc0_out) && $stable(cc1_out));

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // R2: a lane masked off statically keeps the old destination value
        a_r2_masked_lane_keeps: assert property (@(posedge clk) disable iff (rst)
            (wr_valid && !wmask[i]) |=> dest_out[i*32 +: 32] == $past(dest_in[i*32 +: 32]));
    end
endmodule

bind ccwb_writeback ccwb_checker #(.LANES(LANES)) i_ccwb_checker (
    .clk       (clk),
    .rst       (rst),
    .run_start (run_start),
    .wr_valid  (wr_valid),
    .wmask     (wmask),
    .cc_rule   (cc_rule),
    .cc_upd_en (cc_upd_en),
    .cc_wr_sel (cc_wr_sel),
    .dest_in   (dest_in),
    .dest_out  (dest_out),
    .cc0_out   (cc0_out),
    .cc1_out   (cc1_out)
);

// File: tb/test_ccwb_writeback.sv
`timescale 1ns/1ps
module test_ccwb_writeback;
    localparam int L  = 4;
    localparam int VW = L * 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          run_start;
    logic          wr_valid;
    logic          int_mode;
    logic          sat_en;
    logic [VW-1:0] result;
    logic [VW-1:0] dest_in;
    logic [L-1:0]  wmask;
    logic          cc_rd_sel;
    logic [2:0]    cc_rule;
    logic [2*L-1:0] cc_swz;
    logic          cc_upd_en;
    logic          cc_wr_sel;
    logic [VW-1:0] dest_out;
    logic [2*L-1:0] cc0_out;
    logic [2*L-1:0] cc1_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [2*L-1:0] m_cc [2];
    logic [VW-1:0]  m_dest;

    localparam logic [31:0] NEG2 = 32'hC000_0000, POS2 = 32'h4000_0000;
    localparam logic [31:0] QNAN = 32'h7FC0_0000, ONE = 32'h3F80_0000;
    localparam logic [7:0]  SW_ID = 8'hE4;

    always #4 clk = ~clk;

    ccwb_writeback i_ccwb_writeback (
        .clk(clk), .rst(rst), .run_start(run_start), .wr_valid(wr_valid),
        .int_mode(int_mode), .sat_en(sat_en), .result(result), .dest_in(dest_in),
        .wmask(wmask), .cc_rd_sel(cc_rd_sel), .cc_rule(cc_rule), .cc_swz(cc_swz),
        .cc_upd_en(cc_upd_en), .cc_wr_sel(cc_wr_sel), .dest_out(dest_out),
        .cc0_out(cc0_out), .cc1_out(cc1_out)
    );

    // ---------------- reference functions (from the requirements) ----------------
    function automatic logic is_nan(input logic [31:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] != 0);
    endfunction

    function automatic logic [31:0] sat_val(input logic [31:0] v, input logic s, input logic im);
        if (!s || im || is_nan(v)) return v;
        if (v[31] && v[30:0] != 0) return 32'h0;
        if (!v[31] && v[30:0] > ONE[30:0]) return ONE;
        return v;
    endfunction

    function automatic logic [1:0] code_of(input logic [31:0] v, input logic im);
        if (im) return ($signed(v) < 0) ? 2'b10 : (v == 0) ? 2'b01 : 2'b00;
        if (is_nan(v)) return 2'b11;
        if (v[30:0] == 0) return 2'b01;
        return v[31] ? 2'b10 : 2'b00;
    endfunction

    function automatic logic rule_ok(input logic [2:0] r, input logic [1:0] c);
        case (r)
            3'd0: return 1'b1;
            3'd1: return 1'b0;
            3'd2: return c == 2'b01;
            3'd3: return c != 2'b01;
            3'd4: return c == 2'b10;
            3'd5: return c == 2'b00 || c == 2'b01;
            3'd6: return c == 2'b10 || c == 2'b01;
            default: return c == 2'b00;
        endcase
    endfunction

    function automatic logic [31:0] pick_val();
        case ($urandom % 11)
            0: return 32'h0000_0000;
            1: return 32'h8000_0000;
            2: return 32'h7F80_0000 | ($urandom % 32'h7F_FFFF + 1);
            3: return 32'h7F80_0000;
            4: return 32'hFF80_0000;
            5: return ONE;
            6: return 32'h3F00_0000;
            7: return 32'hC040_0000;
            8: return POS2;
            9: return 32'h3F80_0001;
            default: return $urandom;
        endcase
    endfunction

    // ---------------- helpers ----------------
    task automatic check(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " dest"}, dest_out, m_dest);
        check({tag, " cc0"}, {{(VW-2*L){1'b0}}, cc0_out}, {{(VW-2*L){1'b0}}, m_cc[0]});
        check({tag, " cc1"}, {{(VW-2*L){1'b0}}, cc1_out}, {{(VW-2*L){1'b0}}, m_cc[1]});
    endtask

    task automatic model_op();
        logic [2*L-1:0] src;
        src = cc_rd_sel ? m_cc[1] : m_cc[0];
        for (int i = 0; i < L; i++) begin
            logic [31:0] v;
            logic [1:0]  c;
            logic        en;
            v  = sat_val(result[i*32 +: 32], sat_en, int_mode);
            c  = int_mode ? code_of(result[i*32 +: 32], 1'b1) : code_of(v, 1'b0);
            en = wmask[i] && rule_ok(cc_rule, src[cc_swz[i*2 +: 2]*2 +: 2]);
            m_dest[i*32 +: 32] = en ? v : dest_in[i*32 +: 32];
            if (en && cc_upd_en) m_cc[cc_wr_sel][i*2 +: 2] = c;
        end
    endtask

    task automatic do_op(input logic [VW-1:0] res, input logic [VW-1:0] din,
                         input logic [L-1:0] msk, input logic [2:0] rl,
                         input logic [7:0] sw, input logic rd, input logic upd,
                         input logic wsel, input logic sat, input logic im);
        @(negedge clk);
        result = res; dest_in = din; wmask = msk; cc_rule = rl; cc_swz = sw;
        cc_rd_sel = rd; cc_upd_en = upd; cc_wr_sel = wsel; sat_en = sat; int_mode = im;
        wr_valid = 1'b1;
        model_op();
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; run_start = 0; wr_valid = 0; int_mode = 0; sat_en = 0;
        result = '0; dest_in = '0; wmask = '0; cc_rd_sel = 0; cc_rule = 0;
        cc_swz = SW_ID; cc_upd_en = 0; cc_wr_sel = 0;
        m_cc[0] = 8'h55; m_cc[1] = 8'h55; m_dest = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1 reset");

        // R2 R7: three-step masked write sequence
        do_op({QNAN, POS2, 32'h0, NEG2}, '0, 4'hF, 3'd0, SW_ID, 0, 1, 0, 0, 0);
        check("R7 step1 dest", dest_out, {QNAN, POS2, 32'h0, NEG2});
        check("R7 step1 cc0", {120'h0, cc0_out}, {120'h0, 8'b11_00_01_10});
        do_op({NEG2, QNAN, POS2, 32'h0}, dest_out, 4'b0111, 3'd0, SW_ID, 0, 1, 0, 0, 0);
        check("R2 step2 dest", dest_out, {QNAN, QNAN, POS2, 32'h0});
        check("R8 step2 cc0", {120'h0, cc0_out}, {120'h0, 8'b11_11_00_01});
        do_op({NEG2, QNAN, 32'h0, POS2}, dest_out, 4'hF, 3'd3, SW_ID, 0, 1, 0, 0, 0);
        check("R3 step3 dest", dest_out, {NEG2, QNAN, 32'h0, 32'h0});
        check("R3 step3 cc0", {120'h0, cc0_out}, {120'h0, 8'b10_11_01_01});
        check("R8 step3 cc1", {120'h0, cc1_out}, {120'h0, 8'h55});

        // R4 R5: load cc1 = (GT,LT,EQ,GT), test with NE through swizzle zyxw
        do_op({ONE, 32'h0, 32'hBF80_0000, ONE}, '0, 4'hF, 3'd0, SW_ID, 0, 1, 1, 0, 0);
        check("R5 cc1 load", {120'h0, cc1_out}, {120'h0, 8'b00_01_10_00});
        do_op({4{32'h40A0_0000}}, '0, 4'hF, 3'd3, 8'hC6, 1, 0, 0, 0, 0);
        check("R4 swizzled NE", dest_out, {32'h40A0_0000, 32'h40A0_0000, 32'h40A0_0000, 32'h0});
        check_all("R4 model");

        // R6 saturation corners
        do_op({QNAN, 32'h8000_0000, 32'h7F80_0000, 32'hC040_0000}, '0, 4'hF, 3'd0, SW_ID, 0, 1, 0, 1, 0);
        check("R6 clamp", dest_out, {QNAN, 32'h8000_0000, ONE, 32'h0});
        check("R7 clamp codes", {120'h0, cc0_out}, {120'h0, 8'b11_01_00_01});

        // R9 integer mode
        do_op({32'hFFFF_FFFF, 32'h0, 32'h0000_0005, 32'h7FC0_0000}, '0, 4'hF, 3'd0, SW_ID, 0, 1, 0, 1, 1);
        check("R9 int dest", dest_out, {32'hFFFF_FFFF, 32'h0, 32'h0000_0005, 32'h7FC0_0000});
        check("R9 int codes", {120'h0, cc0_out}, {120'h0, 8'b10_01_00_00});

        // R1: run_start clears codes, wins over a same-cycle update
        @(negedge clk);
        run_start = 1'b1; wr_valid = 1'b1; cc_upd_en = 1'b1; cc_rule = 3'd0; wmask = 4'hF;
        int_mode = 1'b0; sat_en = 1'b0; result = {4{NEG2}}; dest_in = '0;
        model_op();
        m_cc[0] = 8'h55; m_cc[1] = 8'h55;
        @(negedge clk);
        run_start = 1'b0; wr_valid = 1'b0;
        check_all("R1 run_start");

        // R10: idle cycles hold outputs
        repeat (3) @(negedge clk);
        check_all("R10 idle hold");

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [VW-1:0] r;
            logic [VW-1:0] d;
            for (int i = 0; i < L; i++) begin
                r[i*32 +: 32] = pick_val();
                d[i*32 +: 32] = $urandom;
            end
            do_op(r, d, L'($urandom), 3'($urandom), 8'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 6) == 0);
            check_all("R2 R3 R4 R5 R6 R7 R8 R9 random");
        end

        finish_run();
    end
endmodule